// File: doc/BRIEF.md
# Head-per-track transfer engine

This engine performs one read or one write on a head-per-track storage array after the command has been decoded elsewhere. A free-running rotor counts word positions under the heads. The position advances by one every word time and wraps at the end of the track. When a start is accepted, the engine waits until the requested word comes round. It then moves one 16-bit word per word time between the array and a single-word buffer that the host fills or drains. Each word is moved as two 8-bit characters.

Every character moved toggles a one-bit running checksum. A write closes with a checksum character. A read closes by fetching one more character and checking that the total parity is even. The engine reports three errors: a word slot that finds the host buffer still unserviced, a character address that runs past the end of the track, and a checksum mismatch. Each transfer finishes with busy dropping and an interrupt request rising.

Write data enters through a valid/ready stream and read data leaves through another. Rotation cannot be stalled, so back-pressure has a limit. The host has until the next word slot to move the buffered word. If it misses that slot, the engine stops with a data error and does not wait.

Top module: `track_xfer`

## Requirements
- R1: `head_pos` advances by exactly one every `WORD_CYCLES` clocks and wraps from `WORDS_PER_TRACK-1` to 0.
- R2: A valid start makes `busy` rise on the next clock. The first word slot occurs at the first clock of the word period in which `head_pos` equals the target word (`cmd_caddr` shifted right by one). If the head has already passed the target, the wait wraps through the end of the track. A read word therefore appears on `m_valid` while `head_pos` shows its slot.
- R3: Character address bit 0 selects the byte lane: 0 selects bits 15:8 and 1 selects bits 7:0. The address increments after every character, and the buffer's upper byte is moved before its lower byte. A transfer may therefore start at an odd address and straddle two stored words.
- R4: In a write, `s_ready` is high from the start, and again after each slot has stored the buffered word. Each accepted word is stored at the next slot.
- R5: In a read, each slot loads two characters into the buffer and raises `m_valid`. `m_data` holds steady until `m_ready` accepts it.
- R6: If a slot arrives while the buffer handshake is still pending (`s_ready` or `m_valid` high), `data_err` is set and the transfer finishes.
- R7: An `end_range` pulse makes the next slot the last one. At that slot a write first stores any word that was accepted but not yet stored. It then stores a checksum character: 0x80 if the number of 1 bits over all characters stored is odd, otherwise 0x00.
- R8: At its last slot a read fetches one further character. `data_err` is set when the count of 1 bits over all characters read, including that one, is odd.
- R9: A character move whose word address equals or exceeds `WORDS_PER_TRACK` sets `acc_err`, stores nothing, and ends the transfer with `busy` low and `irq` high.
- R10: A start with a surface at or above `SURFACES`, a track at or above `TRACKS`, or a word address at or above `WORDS_PER_TRACK` sets `acc_err` and `irq` at once. In that case `busy` stays low.
- R11: A start while `busy` is high is ignored, and the running transfer continues unchanged.
- R12: After reset, `busy`, `irq`, `data_err`, `acc_err`, `s_ready` and `m_valid` are low, and `head_pos` is 0.
- R13: An accepted start clears `irq`, `data_err` and `acc_err`. Every finish drops `busy` and raises `irq`, and `irq` is never high while `busy` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse; command fields sampled with it |
| cmd_write | input | 1 | 1 = write to the array, 0 = read |
| cmd_surf | input | 4 | Surface number |
| cmd_track | input | 6 | Track number on the surface |
| cmd_caddr | input | $clog2(2*WORDS_PER_TRACK)+1 | Starting character address |
| end_range | input | 1 | Pulse: the next slot ends the transfer |
| s_valid | input | 1 | Write word offered by the host |
| s_ready | output | 1 | Buffer free for a write word |
| s_data | input | 16 | Write word |
| m_valid | output | 1 | Read word held in the buffer |
| m_ready | input | 1 | Host takes the read word |
| m_data | output | 16 | Read word |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | Transfer finished |
| data_err | output | 1 | Overrun or checksum error |
| acc_err | output | 1 | Address outside the array |
| head_pos | output | $clog2(WORDS_PER_TRACK) | Word currently under the heads |

## Verification
The bench builds the engine with 16 words per track, 2 tracks, 2 surfaces and 8 clocks per word. With a 16-word track, a full revolution takes 128 clocks. This makes the wrapped seek reachable, along with the last word of a track and the overflow into word 16, all in a few hundred cycles. The two-by-two geometry puts the surface and track limits within reach, and lets separate transfers run without overwriting each other's data. Read-back after write checks the byte lanes, the odd start address and the checksum character through the ports alone.

// File: rtl/track_xfer_pkg.sv
package track_xfer_pkg;

  localparam int SURF_W = 4;
  localparam int TRK_W  = 6;
  localparam int WORD_W = 16;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_SEEK,
    XS_RUN,
    XS_CH_HI,
    XS_CH_LO,
    XS_CH_SUM
  } xfer_state_e;

  function automatic logic char_par(input logic [CHAR_W-1:0] c);
    return ^c;
  endfunction

endpackage

// File: rtl/track_xfer_rotor.sv
module track_xfer_rotor #(
  parameter int WORDS       = 1536,
  parameter int WORD_CYCLES = 10,
  localparam int POS_W = $clog2(WORDS),
  localparam int CYC_W = $clog2(WORD_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] pos,
  output logic             word_start
);

  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(WORD_CYCLES - 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(WORDS - 1);

  logic [CYC_W-1:0] cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc <= '0;
      pos <= '0;
    end else if (cyc == CYC_LAST) begin
      cyc <= '0;
      pos <= (pos == POS_LAST) ? '0 : pos + 1'b1;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  assign word_start = (cyc == '0);

endmodule

// File: rtl/track_xfer_store.sv
module track_xfer_store #(
  parameter int DEPTH = 1536,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          lane_lo,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wchar,
  output logic [15:0]   rword,
  output logic [1:0]    lane_we
);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    assign lane_we[g] = we && (lane_lo == (g == 1));

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[addr] <= wchar;
    end

    assign rword[15-8*g -: 8] = mem[addr];
  end

endmodule

// File: rtl/track_xfer.sv
module track_xfer
  import track_xfer_pkg::*;
#(
  parameter int WORDS_PER_TRACK = 1536,
  parameter int TRACKS          = 1,
  parameter int SURFACES        = 1,
  parameter int WORD_CYCLES     = 10,
  localparam int POS_W = $clog2(WORDS_PER_TRACK),
  localparam int CA_W  = $clog2(2*WORDS_PER_TRACK) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cmd_write,
  input  logic [SURF_W-1:0] cmd_surf,
  input  logic [TRK_W-1:0]  cmd_track,
  input  logic [CA_W-1:0]   cmd_caddr,
  input  logic              end_range,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [15:0]       s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [15:0]       m_data,
  output logic              busy,
  output logic              irq,
  output logic              data_err,
  output logic              acc_err,
  output logic [POS_W-1:0]  head_pos
);

  localparam int DEPTH = SURFACES * TRACKS * WORDS_PER_TRACK;
  localparam int AW    = $clog2(DEPTH);
  localparam int WA_W  = CA_W - 1;
  localparam logic [WA_W-1:0] WA_LIM = WA_W'(WORDS_PER_TRACK);

  xfer_state_e       state;
  logic              wr_q, rdy_q, eor_q, fin_q, csum_q;
  logic              busy_q, irq_q, dte_q, ace_q;
  logic [SURF_W-1:0] surf_q;
  logic [TRK_W-1:0]  trk_q;
  logic [CA_W-1:0]   ca_q;
  logic [POS_W-1:0]  tgt_q;
  logic [15:0]       buf_q;

  logic              word_start;
  logic [POS_W-1:0]  pos;
  logic [WA_W-1:0]   wa;
  logic              wa_bad;
  logic [AW-1:0]     mem_addr;
  logic [15:0]       rword;
  logic [1:0]        lane_we;
  logic [7:0]        out_char, in_char, mv_char;
  logic              char_op, st_we, slot_go;
  logic              s_fire, m_fire, cmd_bad;

  // rotation model
  track_xfer_rotor #(
    .WORDS       (WORDS_PER_TRACK),
    .WORD_CYCLES (WORD_CYCLES)
  ) u_rotor (
    .clk        (clk),
    .rst_n      (rst_n),
    .pos        (pos),
    .word_start (word_start)
  );

  // addressing of the current character
  assign wa       = ca_q[CA_W-1:1];
  assign wa_bad   = (wa >= WA_LIM);
  assign mem_addr = AW'((32'(surf_q) * 32'(TRACKS) + 32'(trk_q))
                        * 32'(WORDS_PER_TRACK) + 32'(wa));

  assign char_op = (state == XS_CH_HI) || (state == XS_CH_LO) ||
                   (state == XS_CH_SUM);

  always_comb begin
    case (state)
      XS_CH_HI: out_char = buf_q[15:8];
      XS_CH_LO: out_char = buf_q[7:0];
      default:  out_char = {csum_q, 7'b0};
    endcase
  end

  assign in_char = ca_q[0] ? rword[7:0] : rword[15:8];
  assign mv_char = wr_q ? out_char : in_char;
  assign st_we   = wr_q && char_op && !wa_bad;

  track_xfer_store #(
    .DEPTH (DEPTH)
  ) u_store (
    .clk     (clk),
    .we      (st_we),
    .lane_lo (ca_q[0]),
    .addr    (mem_addr),
    .wchar   (mv_char),
    .rword   (rword),
    .lane_we (lane_we)
  );

  // start validation
  assign cmd_bad = (32'(cmd_surf) >= 32'(SURFACES)) ||
                   (32'(cmd_track) >= 32'(TRACKS)) ||
                   (cmd_caddr[CA_W-1:1] >= WA_LIM);

  // word slot trigger
  assign slot_go = word_start &&
                   (((state == XS_SEEK) && (pos == tgt_q)) || (state == XS_RUN));

  // host buffer handshake
  assign s_ready = busy_q && wr_q && rdy_q;
  assign m_valid = busy_q && !wr_q && rdy_q;
  assign s_fire  = s_valid && s_ready;
  assign m_fire  = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= XS_IDLE;
      wr_q   <= 1'b0;
      rdy_q  <= 1'b0;
      eor_q  <= 1'b0;
      fin_q  <= 1'b0;
      csum_q <= 1'b0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      dte_q  <= 1'b0;
      ace_q  <= 1'b0;
      surf_q <= '0;
      trk_q  <= '0;
      ca_q   <= '0;
      tgt_q  <= '0;
      buf_q  <= '0;
    end else begin
      if (s_fire) begin
        buf_q <= s_data;
        rdy_q <= 1'b0;
      end
      if (m_fire) rdy_q <= 1'b0;
      if (end_range && busy_q) eor_q <= 1'b1;

      case (state)
        XS_IDLE: begin
          if (start) begin
            irq_q  <= 1'b0;
            dte_q  <= 1'b0;
            ace_q  <= 1'b0;
            eor_q  <= 1'b0;
            fin_q  <= 1'b0;
            csum_q <= 1'b0;
            wr_q   <= cmd_write;
            surf_q <= cmd_surf;
            trk_q  <= cmd_track;
            ca_q   <= cmd_caddr;
            tgt_q  <= cmd_caddr[POS_W:1];
            if (cmd_bad) begin
              ace_q <= 1'b1;
              irq_q <= 1'b1;
            end else begin
              busy_q <= 1'b1;
              rdy_q  <= cmd_write;
              state  <= XS_SEEK;
            end
          end
        end

        XS_SEEK, XS_RUN: begin
          if (slot_go) begin
            if (eor_q || rdy_q) begin
              fin_q <= 1'b1;
              if (rdy_q) dte_q <= 1'b1;
              state <= (wr_q && !rdy_q) ? XS_CH_HI : XS_CH_SUM;
            end else begin
              fin_q <= 1'b0;
              state <= XS_CH_HI;
            end
          end
        end

        XS_CH_HI, XS_CH_LO: begin
          if (wa_bad) begin
            ace_q  <= 1'b1;
            busy_q <= 1'b0;
            irq_q  <= 1'b1;
            rdy_q  <= 1'b0;
            state  <= XS_IDLE;
          end else begin
            ca_q   <= ca_q + 1'b1;
            csum_q <= csum_q ^ char_par(mv_char);
            if (state == XS_CH_HI) begin
              if (!wr_q) buf_q[15:8] <= in_char;
              state <= XS_CH_LO;
            end else begin
              if (!wr_q) buf_q[7:0] <= in_char;
              if (fin_q) begin
                state <= XS_CH_SUM;
              end else begin
                rdy_q <= 1'b1;
                state <= XS_RUN;
              end
            end
          end
        end

        XS_CH_SUM: begin
          if (wa_bad) begin
            ace_q <= 1'b1;
          end else begin
            ca_q <= ca_q + 1'b1;
            if (!wr_q && (csum_q ^ char_par(in_char))) dte_q <= 1'b1;
          end
          busy_q <= 1'b0;
          irq_q  <= 1'b1;
          rdy_q  <= 1'b0;
          state  <= XS_IDLE;
        end

        default: state <= XS_IDLE;
      endcase
    end
  end

  assign m_data   = buf_q;
  assign busy     = busy_q;
  assign irq      = irq_q;
  assign data_err = dte_q;
  assign acc_err  = ace_q;
  assign head_pos = pos;

endmodule

// File: rtl/track_xfer_chk.sv
module track_xfer_chk #(
  parameter int WORDS = 1536,
  localparam int POS_W = $clog2(WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             irq,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [15:0]      m_data,
  input logic [POS_W-1:0] head_pos,
  input logic [1:0]       lane_we
);

  localparam logic [POS_W-1:0] POS_LAST = POS_W'(WORDS - 1);

  // R1: position moves only by one step with wrap
  a_r1_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
    (head_pos != $past(head_pos)) |->
      (head_pos == (($past(head_pos) == POS_LAST) ? '0 : $past(head_pos) + 1'b1)));

  // R3: a character lands in one byte lane at most
  a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_we));

  // R4: the buffer faces one direction only
  a_r4_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_ready && m_valid));

  // R4: no handshake outside a transfer
  a_r4_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!s_ready && !m_valid));

  // R5: read word held until taken
  a_r5_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (!m_valid || $stable(m_data)));

  // R9: nothing stored while idle
  a_r9_no_store_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (lane_we == 2'b00));

  // R13: interrupt never overlaps a transfer
  a_r13_irq_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !irq);

  // R13: every finish raises the interrupt
  a_r13_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq);

endmodule

bind track_xfer track_xfer_chk #(.WORDS(WORDS_PER_TRACK)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .irq      (irq),
  .s_ready  (s_ready),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_data   (m_data),
  .head_pos (head_pos),
  .lane_we  (lane_we)
);

// File: tb/track_xfer_bench.sv
`timescale 1ns/1ps
module track_xfer_bench;

  localparam int W    = 16;
  localparam int TRK  = 2;
  localparam int SRF  = 2;
  localparam int WC   = 8;
  localparam int POSW = $clog2(W);
  localparam int CAW  = $clog2(2*W) + 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic            cmd_write = 1'b0;
  logic [3:0]      cmd_surf = '0;
  logic [5:0]      cmd_track = '0;
  logic [CAW-1:0]  cmd_caddr = '0;
  logic            end_range = 1'b0;
  logic            s_valid = 1'b0;
  logic            s_ready;
  logic [15:0]     s_data = '0;
  logic            m_valid;
  logic            m_ready = 1'b0;
  logic [15:0]     m_data;
  logic            busy, irq, data_err, acc_err;
  logic [POSW-1:0] head_pos;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  track_xfer #(
    .WORDS_PER_TRACK (W),
    .TRACKS          (TRK),
    .SURFACES        (SRF),
    .WORD_CYCLES     (WC)
  ) u_track_xfer (
    .clk (clk), .rst_n (rst_n), .start (start), .cmd_write (cmd_write),
    .cmd_surf (cmd_surf), .cmd_track (cmd_track), .cmd_caddr (cmd_caddr),
    .end_range (end_range), .s_valid (s_valid), .s_ready (s_ready),
    .s_data (s_data), .m_valid (m_valid), .m_ready (m_ready),
    .m_data (m_data), .busy (busy), .irq (irq), .data_err (data_err),
    .acc_err (acc_err), .head_pos (head_pos)
  );

  function automatic logic p8(input logic [7:0] c);
    return ^c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_cmd(input logic wr, input logic [3:0] s, input logic [5:0] t,
                           input logic [CAW-1:0] ca);
    @(negedge clk);
    start = 1'b1; cmd_write = wr; cmd_surf = s; cmd_track = t; cmd_caddr = ca;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic push_word(input logic [15:0] d, input bit last);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_data = d; end_range = last;
    @(negedge clk);
    s_valid = 1'b0; end_range = 1'b0;
  endtask

  task automatic pull_word(output logic [15:0] d, output logic [POSW-1:0] p, input bit last);
    while (!m_valid) @(negedge clk);
    d = m_data; p = head_pos;
    m_ready = 1'b1; end_range = last;
    @(negedge clk);
    m_ready = 1'b0; end_range = 1'b0;
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R12 busy", 32'(busy), 0);
    check("R12 irq", 32'(irq), 0);
    check("R12 errors", {30'b0, data_err, acc_err}, 0);
    check("R12 handshake", {30'b0, s_ready, m_valid}, 0);
    check("R12 head_pos", 32'(head_pos), 0);
  endtask

  task automatic t_rotation();
    logic [POSW-1:0] p;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      p = head_pos;
      repeat (WC) @(negedge clk);
      check("R1 step", 32'(head_pos), 32'((p + 1) % W));
    end
    while (head_pos != POSW'(W-1)) @(negedge clk);
    repeat (WC) @(negedge clk);
    check("R1 wrap", 32'(head_pos), 0);
  endtask

  // words 3..6 of surface 1 track 0
  task automatic t_write_read();
    logic [15:0] d [4];
    logic [15:0] got;
    logic [POSW-1:0] p;
    d[0] = 16'h1234; d[1] = 16'hF00F; d[2] = 16'h8001; d[3] = 16'h7E55;
    start_cmd(1'b1, 4'd1, 6'd0, 6'd6);
    check("R13 busy after start", {30'b0, busy, irq}, 32'h2);
    check("R4 s_ready at start", 32'(s_ready), 1);
    for (int i = 0; i < 4; i++) push_word(d[i], i == 3);
    wait_done();
    check("R7 write clean", {30'b0, data_err, acc_err}, 0);
    check("R13 irq after write", 32'(irq), 1);
    start_cmd(1'b0, 4'd1, 6'd0, 6'd6);
    for (int i = 0; i < 4; i++) begin
      pull_word(got, p, i == 3);
      check("R5 read data", 32'(got), 32'(d[i]));
      check("R2 slot position", 32'(p), 32'(3 + i));
    end
    wait_done();
    check("R8 checksum good", 32'(data_err), 0);
    check("R13 irq after read", {30'b0, irq, busy}, 32'h2);
  endtask

  task automatic t_wrap_seek();
    logic [15:0] got;
    logic [POSW-1:0] p;
    @(negedge clk);
    while (head_pos != POSW'(12)) @(negedge clk);
    start_cmd(1'b0, 4'd1, 6'd0, 6'd8);
    pull_word(got, p, 1'b1);
    check("R2 wrapped slot", 32'(p), 4);
    check("R5 wrapped data", 32'(got), 32'h0000F00F);
    wait_done();
    check("R8 parity with next char", 32'(data_err), 32'(p8(8'hF0) ^ p8(8'h0F) ^ p8(8'h80)));
  endtask

  task automatic t_odd_lane();
    logic [15:0] got;
    logic [POSW-1:0] p;
    start_cmd(1'b1, 4'd0, 6'd1, 6'd10);
    push_word(16'h1111, 1'b0);
    push_word(16'h2222, 1'b1);
    wait_done();
    start_cmd(1'b1, 4'd0, 6'd1, 6'd11);
    push_word(16'hA1B2, 1'b1);
    wait_done();
    check("R3 odd write clean", 32'(data_err), 0);
    start_cmd(1'b0, 4'd0, 6'd1, 6'd10);
    pull_word(got, p, 1'b0);
    check("R3 low lane", 32'(got), 32'h000011A1);
    pull_word(got, p, 1'b1);
    check("R7 checksum char 0x80", 32'(got), 32'h0000B280);
    wait_done();
    check("R8 read parity even", 32'(data_err), 0);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] got;
    logic [POSW-1:0] p;
    start_cmd(1'b0, 4'd1, 6'd0, 6'd6);
    start_cmd(1'b1, 4'd0, 6'd0, 6'd0);
    check("R11 still reading", {30'b0, busy, s_ready}, 32'h2);
    pull_word(got, p, 1'b1);
    check("R11 original address", 32'(got), 32'h00001234);
    wait_done();
    check("R8 odd parity", 32'(data_err), 32'(p8(8'h12) ^ p8(8'h34) ^ p8(8'hF0)));
  endtask

  task automatic t_overrun();
    start_cmd(1'b0, 4'd1, 6'd0, 6'd6);
    wait_done();
    check("R6 read overrun", {30'b0, data_err, acc_err}, 32'h2);
    check("R6 read overrun irq", 32'(irq), 1);
    start_cmd(1'b1, 4'd1, 6'd1, 6'd0);
    wait_done();
    check("R6 write overrun", {30'b0, data_err, acc_err}, 32'h2);
  endtask

  task automatic t_overflow();
    logic [15:0] got;
    logic [POSW-1:0] p;
    start_cmd(1'b1, 4'd0, 6'd1, 6'd0);
    push_word(16'h5A5A, 1'b1);
    wait_done();
    start_cmd(1'b1, 4'd0, 6'd0, 6'd30);
    push_word(16'hCAFE, 1'b0);
    push_word(16'hBEEF, 1'b0);
    wait_done();
    check("R9 overflow error", {30'b0, acc_err, busy}, 32'h2);
    check("R9 overflow irq", 32'(irq), 1);
    start_cmd(1'b0, 4'd0, 6'd1, 6'd0);
    pull_word(got, p, 1'b1);
    check("R9 next track untouched", 32'(got), 32'h00005A5A);
    wait_done();
    check("R9 next track parity", {30'b0, data_err, acc_err}, 0);
    start_cmd(1'b0, 4'd0, 6'd0, 6'd30);
    pull_word(got, p, 1'b1);
    check("R9 last word stored", 32'(got), 32'h0000CAFE);
    wait_done();
    check("R9 checksum read overflows", 32'(acc_err), 1);
  endtask

  task automatic t_bad_start();
    start_cmd(1'b0, 4'd2, 6'd0, 6'd0);
    check("R10 bad surface", {29'b0, acc_err, irq, busy}, 32'h6);
    start_cmd(1'b0, 4'd0, 6'd2, 6'd0);
    check("R10 bad track", {29'b0, acc_err, irq, busy}, 32'h6);
    start_cmd(1'b1, 4'd0, 6'd0, 6'd32);
    check("R10 bad address", {29'b0, acc_err, irq, busy}, 32'h6);
    start_cmd(1'b0, 4'd1, 6'd0, 6'd6);
    check("R13 errors cleared", {29'b0, acc_err, irq, busy}, 32'h1);
    wait_done();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rotation();
    t_write_read();
    t_wrap_seek();
    t_odd_lane();
    t_busy_ignore();
    t_overrun();
    t_overflow();
    t_bad_start();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule